// File: doc/BRIEF.md
# Receive Character FIFO with Mode-Dependent Status Flags

This block buffers received 12-bit characters between a character-rate write port and a parallel read port, using a 256-entry first-in first-out store. Both ports share one clock. The consumer reads one character per clock while its read request is active. The read request pin and the full-flag pin are active high in cascade timing and active low in the alternate cell-bus timing. The half-full pin is active low in both timings.

A bypass setting skips the store. Each incoming character goes into a single output register, and the read bus takes that register's contents on every clock with an active read request. In bypass both status flags are forced inactive. A self-test setting turns the full flag into a progress pulse, one per pass of a 511-character loop.

Output enables model the three-state pins. The full-flag enable follows an address-match input. The half-full enable drops only while both reset pins are low. The read-bus enable follows the read request. If either reset pin is low, the store empties and the sticky overflow indication clears.

Top module: `rx_char_fifo`

## Requirements
- R1: `rd_en_pin` requests a read when it equals `cascade_mode`. That is, it is active high with `cascade_mode`=1 and active low with `cascade_mode`=0. `full_pin` uses the same polarity: it carries the full condition when `cascade_mode`=1 and its inverse when `cascade_mode`=0.
- R2: Characters are read in write order, one per rising edge with an active read request while the store holds data. A read request on an empty store leaves `rd_data` and the read position unchanged.
- R3: `rd_data_oe` is 1 in the cycle after an edge at which a read was requested, and 0 after an edge at which no read was requested.
- R4: After any edge that leaves 248 or more characters stored (eight or fewer free slots), the full condition is true. Below 248 it is false.
- R5: `half_n` is 0 after any edge that leaves 128 or more characters stored, and 1 otherwise, in both timings.
- R6: A write while 256 characters are stored is dropped and sets `overflow`. `overflow` stays at 1 until a mode reset.
- R7: A read and a write at the same edge leave the stored count unchanged.
- R8: While `bypass_en`=1, the full condition and the half condition are both false after the next edge. The store is neither written nor read. `wr_data` at a write edge loads the output register, and that value reaches `rd_data` at a later edge with an active read request.
- R9: `full_oe` equals `addr_match`.
- R10: `half_oe` is 0 exactly while `reset_pins_n` is 2'b00.
- R11: While `bist_on`=1, the full condition is true for exactly one cycle per 511 edges. The first pulse follows the 511th edge after `bist_on` is raised.
- R12: If `reset_pins_n` differs from 2'b11 at an edge, the store empties and `overflow` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_pins_n | input | 2 | Mode-reset pins, active low |
| cascade_mode | input | 1 | 1 = cascade timing, 0 = cell-bus timing |
| bypass_en | input | 1 | 1 = route characters around the store |
| addr_match | input | 1 | Enables the full-flag pin |
| bist_on | input | 1 | Self-test progress mode |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 12 | Character to write |
| rd_en_pin | input | 1 | Read request, polarity set by timing |
| rd_data | output | 12 | Read character |
| rd_data_oe | output | 1 | Read bus drive enable |
| full_pin | output | 1 | Full flag, polarity set by timing |
| full_oe | output | 1 | Full flag drive enable |
| half_n | output | 1 | Half-full flag, active low |
| half_oe | output | 1 | Half-full drive enable |
| overflow | output | 1 | Sticky dropped-write indication |

## Verification
The main function is exercised with four input patterns:
- A short interleaved sequence of writes, reads and simultaneous read-write cycles. It separates correct ordering from pointer slips, and correct counting from a count that double-steps or misses a step.
- A full fill followed by a full drain. It places both flag thresholds at their exact counts and exposes a wrap error at the end of the store.
- A drain run in cell-bus timing. It tells an inverted read request or full pin apart from the correct one.
- A store held at 128 characters across a bypass interval. It shows that bypass traffic leaves the stored contents intact while the flags go quiet.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

  typedef enum logic {
    TIMING_CELLBUS = 1'b0,
    TIMING_CASCADE = 1'b1
  } timing_e;

  localparam int unsigned CHAR_W      = 12;
  localparam int unsigned STORE_DEPTH = 256;

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_fire,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count_next,
  output logic              overflow
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  count_q;
  logic              ovf_q, ovf_d;
  logic              is_full, is_empty, wr_go, rd_go;

  assign is_full  = (count_q == CNT_W'(DEPTH));
  assign is_empty = (count_q == '0);
  assign wr_go    = wr_req && !is_full && !clear;
  assign rd_go    = rd_req && !is_empty && !clear;
  assign rd_fire  = rd_go;
  assign head_data = mem[rptr_q];

  always_comb begin
    wptr_d     = wptr_q;
    rptr_d     = rptr_q;
    count_next = count_q;
    ovf_d      = ovf_q;
    if (clear) begin
      wptr_d     = '0;
      rptr_d     = '0;
      count_next = '0;
      ovf_d      = 1'b0;
    end else begin
      if (wr_req && is_full) ovf_d = 1'b1;
      if (wr_go) wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + PTR_W'(1);
      if (rd_go) rptr_d = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + PTR_W'(1);
      unique case ({wr_go, rd_go})
        2'b10:   count_next = count_q + CNT_W'(1);
        2'b01:   count_next = count_q - CNT_W'(1);
        default: count_next = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      count_q <= count_next;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr_q] <= wr_data;
  end

  assign overflow = ovf_q;

  assert_empty_read_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && is_empty && !clear) |=> (rptr_q == $past(rptr_q)));

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clear) |=> ovf_q);

  assert_count_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_go) |=> (count_q == $past(count_q)));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/rx_fifo_flags.sv
module rx_fifo_flags #(
  parameter int unsigned DEPTH      = 256,
  parameter int unsigned FULL_SLACK = 8,
  parameter int unsigned BIST_LEN   = 511,
  localparam int unsigned CNT_W     = $clog2(DEPTH) + 1,
  localparam int unsigned BW        = $clog2(BIST_LEN),
  localparam int unsigned FULL_AT   = DEPTH - FULL_SLACK,
  localparam int unsigned HALF_AT   = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bypass,
  input  logic             bist_on,
  input  logic [CNT_W-1:0] count_next,
  output logic             full_flag,
  output logic             half_flag
);

  logic [BW-1:0] bist_cnt_q, bist_cnt_d;
  logic          bist_wrap;
  logic          full_d, half_d;

  assign bist_wrap = (bist_cnt_q == BW'(BIST_LEN - 1));

  always_comb begin
    bist_cnt_d = bist_cnt_q;
    if (clear || !bist_on) bist_cnt_d = '0;
    else if (bist_wrap)     bist_cnt_d = '0;
    else                    bist_cnt_d = bist_cnt_q + BW'(1);
  end

  always_comb begin
    full_d = 1'b0;
    half_d = 1'b0;
    if (bist_on && !clear) begin
      full_d = bist_wrap;
    end else if (!bypass) begin
      full_d = (count_next >= CNT_W'(FULL_AT));
      half_d = (count_next >= CNT_W'(HALF_AT));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bist_cnt_q <= '0;
      full_flag  <= 1'b0;
      half_flag  <= 1'b0;
    end else begin
      bist_cnt_q <= bist_cnt_d;
      full_flag  <= full_d;
      half_flag  <= half_d;
    end
  end

  assert_bypass_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !bist_on) |=> (!full_flag && !half_flag));

  assert_bist_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bist_cnt_q) < BIST_LEN));

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = CHAR_W,
  parameter int unsigned DEPTH      = STORE_DEPTH,
  parameter int unsigned FULL_SLACK = 8,
  parameter int unsigned BIST_LEN   = 511
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reset_pins_n,
  input  logic              cascade_mode,
  input  logic              bypass_en,
  input  logic              addr_match,
  input  logic              bist_on,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_pin,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_oe,
  output logic              full_pin,
  output logic              full_oe,
  output logic              half_n,
  output logic              half_oe,
  output logic              overflow
);

  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  timing_e           mode;
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              clear, rd_active, rd_fire;
  logic [DATA_W-1:0] head_data, byp_q, byp_d, rdat_q, rdat_d;
  logic              oe_q;
  logic [CNT_W-1:0]  count_next;
  logic              full_flag, half_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode      = timing_e'(cascade_mode);
  assign rd_active = (mode == TIMING_CASCADE) ? rd_en_pin : !rd_en_pin;
  assign clear     = (reset_pins_n != 2'b11);

  rx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear      (clear),
    .wr_req     (wr_en && !bypass_en),
    .wr_data    (wr_data),
    .rd_req     (rd_active && !bypass_en),
    .rd_fire    (rd_fire),
    .head_data  (head_data),
    .count_next (count_next),
    .overflow   (overflow)
  );

  rx_fifo_flags #(.DEPTH(DEPTH), .FULL_SLACK(FULL_SLACK), .BIST_LEN(BIST_LEN)) u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear      (clear),
    .bypass     (bypass_en),
    .bist_on    (bist_on),
    .count_next (count_next),
    .full_flag  (full_flag),
    .half_flag  (half_flag)
  );

  always_comb begin
    byp_d  = byp_q;
    rdat_d = rdat_q;
    if (bypass_en) begin
      if (wr_en)     byp_d  = wr_data;
      if (rd_active) rdat_d = byp_q;
    end else if (rd_fire) begin
      rdat_d = head_data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      byp_q  <= '0;
      rdat_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      byp_q  <= byp_d;
      rdat_q <= rdat_d;
      oe_q   <= rd_active;
    end
  end

  assign rd_data    = rdat_q;
  assign rd_data_oe = oe_q;
  assign full_pin   = (mode == TIMING_CASCADE) ? full_flag : !full_flag;
  assign full_oe    = addr_match;
  assign half_n     = !half_flag;
  assign half_oe    = (reset_pins_n != 2'b00);

  assert_rd_oe_on_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_active |=> rd_data_oe);

  assert_rd_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_active |=> !rd_data_oe);

  assert_bypass_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bypass_en && !rd_active) |=> $stable(rd_data));

endmodule

// File: tb/test_rx_char_fifo.sv
module test_rx_char_fifo;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reset_pins_n;
  logic        cascade_mode, bypass_en, addr_match, bist_on, wr_en, rd_en_pin;
  logic [11:0] wr_data, rd_data;
  logic        rd_data_oe, full_pin, full_oe, half_n, half_oe, overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rx_char_fifo i_rx_char_fifo (
    .clk(clk), .rst_n(rst_n), .reset_pins_n(reset_pins_n),
    .cascade_mode(cascade_mode), .bypass_en(bypass_en), .addr_match(addr_match),
    .bist_on(bist_on), .wr_en(wr_en), .wr_data(wr_data), .rd_en_pin(rd_en_pin),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .full_pin(full_pin),
    .full_oe(full_oe), .half_n(half_n), .half_oe(half_oe), .overflow(overflow)
  );

  // fields: [27] write, [26:15] data, [14] read, [13] expected oe,
  // [12:1] expected data, [0] compare data
  localparam logic [27:0] VEC [9] = '{
    {1'b1, 12'h0A1, 1'b0, 1'b0, 12'h000, 1'b0},
    {1'b1, 12'h0B2, 1'b0, 1'b0, 12'h000, 1'b0},
    {1'b1, 12'h0C3, 1'b1, 1'b1, 12'h0A1, 1'b1},
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h0B2, 1'b1},
    {1'b1, 12'h0D4, 1'b1, 1'b1, 12'h0C3, 1'b1},
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h0D4, 1'b1},
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h0D4, 1'b1},
    {1'b1, 12'h0E5, 1'b0, 1'b0, 12'h0D4, 1'b0},
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h0E5, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [11:0] last;
    int first_pulse, pulses;
    rst_n = 1'b0; reset_pins_n = 2'b11; cascade_mode = 1'b1; bypass_en = 1'b0;
    addr_match = 1'b1; bist_on = 1'b0; wr_en = 1'b0; wr_data = '0; rd_en_pin = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // reset state
    check("R3 reset oe", rd_data_oe, 0);
    check("R4 reset full", full_pin, 0);
    check("R5 reset half", half_n, 1);
    check("R6 reset overflow", overflow, 0);
    check("R10 reset half_oe", half_oe, 1);
    check("R9 reset full_oe", full_oe, 1);

    // vector table: ordering, empty read, simultaneous read and write (R2, R3, R7)
    for (int k = 0; k < 9; k++) begin
      wr_en = VEC[k][27]; wr_data = VEC[k][26:15]; rd_en_pin = VEC[k][14];
      step();
      check("R3 table oe", rd_data_oe, VEC[k][13]);
      if (VEC[k][0]) check("R2 R7 table data", rd_data, VEC[k][12:1]);
    end
    wr_en = 1'b0; rd_en_pin = 1'b0;

    // fill to the top: thresholds R4, R5
    for (int i = 0; i < 256; i++) begin
      wr_en = 1'b1; wr_data = 12'(i * 7 + 3);
      step();
      check("R5 fill half", half_n, (i + 1 >= 128) ? 0 : 1);
      check("R4 fill full", full_pin, (i + 1 >= 248) ? 1 : 0);
    end
    wr_data = 12'hFFF;
    step();
    wr_en = 1'b0;
    check("R6 overflow set", overflow, 1);
    step();
    check("R6 overflow sticky", overflow, 1);

    // cell-bus timing: inverted pins R1
    cascade_mode = 1'b0; rd_en_pin = 1'b1;
    #1;
    check("R1 full pin low-active", full_pin, 0);
    step();
    check("R1 inactive high pin no read", rd_data_oe, 0);
    rd_en_pin = 1'b0;
    for (int i = 0; i < 256; i++) begin
      step();
      check("R2 R1 drain order", rd_data, 12'(i * 7 + 3));
    end
    check("R1 full pin idle", full_pin, 1);
    step();
    check("R2 empty read holds", rd_data, 12'(255 * 7 + 3));
    rd_en_pin = 1'b1;
    step();
    check("R3 oe off", rd_data_oe, 0);
    cascade_mode = 1'b1; rd_en_pin = 1'b0;

    // mode reset R12, R10
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1; wr_data = 12'h700 + 12'(i);
      step();
    end
    wr_en = 1'b0; reset_pins_n = 2'b01;
    step();
    check("R12 overflow cleared", overflow, 0);
    check("R10 half_oe one pin low", half_oe, 1);
    reset_pins_n = 2'b11;
    last = rd_data;
    rd_en_pin = 1'b1;
    step();
    check("R12 store emptied", rd_data, last);
    rd_en_pin = 1'b0;

    // count with simultaneous traffic R7, bypass R8
    for (int i = 0; i < 128; i++) begin
      wr_en = 1'b1; wr_data = 12'h200 + 12'(i);
      step();
    end
    check("R5 half at 128", half_n, 0);
    wr_data = 12'h5AA; rd_en_pin = 1'b1;
    step();
    check("R7 simultaneous keeps half", half_n, 0);
    check("R7 simultaneous data", rd_data, 12'h200);
    wr_en = 1'b0; rd_en_pin = 1'b0; bypass_en = 1'b1;
    step();
    check("R8 bypass half off", half_n, 1);
    check("R8 bypass full off", full_pin, 0);
    wr_en = 1'b1; wr_data = 12'h3C5;
    step();
    wr_en = 1'b0; rd_en_pin = 1'b1;
    step();
    check("R8 bypass data", rd_data, 12'h3C5);
    rd_en_pin = 1'b0; bypass_en = 1'b0;
    step();
    check("R8 store untouched", half_n, 0);
    rd_en_pin = 1'b1;
    step();
    rd_en_pin = 1'b0;
    check("R7 next after simultaneous", rd_data, 12'h201);
    check("R7 half drops at 127", half_n, 1);

    // enables R9, R10
    addr_match = 1'b0;
    #1;
    check("R9 full_oe off", full_oe, 0);
    addr_match = 1'b1;
    #1;
    check("R9 full_oe on", full_oe, 1);
    reset_pins_n = 2'b00;
    #1;
    check("R10 half_oe off", half_oe, 0);
    step();
    reset_pins_n = 2'b11;
    #1;
    check("R10 half_oe back", half_oe, 1);

    // self-test pulses R11
    bist_on = 1'b1; first_pulse = -1; pulses = 0;
    for (int n = 1; n <= 1100; n++) begin
      step();
      if (full_pin) begin
        pulses++;
        if (first_pulse < 0) first_pulse = n;
      end
    end
    bist_on = 1'b0;
    check("R11 first pulse edge", first_pulse, 511);
    check("R11 pulse count", pulses, 2);
    step();
    check("R11 pulse off after test", full_pin, 0);

    finish_run();
  end

endmodule